// File: doc/BRIEF.md
# Page-Based Record and Playback Sequencer

This block drives two speech channels over a shared memory address space: channel 0 records and channel 1 plays back. Encoded speech is kept in pages of 1024 bits. Each channel takes a 16-bit command that gives a page count and a start page. For every sample tick it then issues one memory request for the next bit address. It steps through the bits of each page, then through the pages, and pulses a completion strobe when the last bit of the last page has been accepted.

A command is either immediate or buffered. An immediate command replaces whatever the channel is doing. A buffered command waits in a one-entry slot and takes over on the very edge where the running command ends, so the next tick already addresses the new sequence. The two channels share nothing but the clock, the reset and the memory-ready input, and they run concurrently.

Both the command input and the memory request output are valid/ready streams:
- Back-pressure on the request stream holds the request and its address steady.
- A tick that arrives while a request is still outstanding is dropped. A slow memory therefore loses samples but never skips or repeats an address.
- An immediate command is always accepted. A buffered command is refused while the slot is occupied.

Top module: `pseq_top`

## Requirements
- R1: A request address is {page, bit}, with the page in bits 21:10 and the bit index in bits 9:0. A new command starts at bit 0 of its start page, and each accepted request advances the bit index by one through 0 to 1023.
- R2: A command word carries the page count in bits 15:12 and the start page in bits 11:0. A count of 1 to 15 runs that many pages, and a count of 0 runs 16 pages (16384 requests).
- R3: Each tick seen while the channel is busy and has no outstanding request raises exactly one request. A tick seen while a request is outstanding is dropped.
- R4: While req_valid is high and req_ready is low, req_valid stays high and the address stays unchanged.
- R5: After bit 1023 the bit index wraps to 0 and the page increments, and page 4095 is followed by page 0.
- R6: done pulses for exactly one cycle, in the cycle after the handshake of the last bit of the last page.
- R7: An immediate command is always accepted. It restarts the channel at its own start page and discards any waiting buffered command, so only the new command completes.
- R8: A buffered command given to an idle channel starts at once. Given to a busy channel, it waits in a single slot, and cmd_ready stays low for further buffered commands until the slot empties. The waiting command starts on the edge where the running one completes, so the spacing of requests across the hand-over equals the tick spacing.
- R9: After completion with nothing waiting, busy goes low and no request is raised whatever the ticks do.
- R10: Both channels run at the same time without influencing each other's addresses or counts.
- R11: After reset, busy, req_valid and done are low, and cmd_ready is high on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 2 | Sample tick per channel (0 record, 1 play), one-cycle pulses |
| cmd_valid | input | 2 | Command offered, per channel |
| cmd_ready | output | 2 | Command accepted when high together with cmd_valid |
| cmd_imm | input | 2 | 1: immediate command, 0: buffered command |
| cmd_word | input | 32 | Command word per channel, channel c in bits 16c+15:16c |
| req_valid | output | 2 | Memory request pending, per channel |
| req_ready | input | 2 | Memory accepts the request |
| req_write | output | 2 | 1 for the record channel, 0 for playback |
| req_addr | output | 44 | Request address per channel, channel c in bits 22c+21:22c |
| busy | output | 2 | Channel is running a command |
| done | output | 2 | One-cycle completion strobe per command |

## Verification
The assertions assume that ticks are single-cycle pulses and that the command word and cmd_imm are stable whenever cmd_valid is high. They also assume that the memory eventually raises req_ready, since a request held forever would make the completion checks vacuous. The stimulus drives all inputs shortly after the rising edge and produces ticks on every other cycle, or one at a time in the back-pressure test. It withholds req_ready only for a bounded stretch and never offers an immediate command in the same cycle as the final handshake, so completion and replacement never coincide.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int PAGE_BIT_W = 10;
  localparam int PAGE_NUM_W = 12;
  localparam int PAGE_CNT_W = 4;
  localparam int CMD_W      = PAGE_CNT_W + PAGE_NUM_W;
  localparam int ADDR_W     = PAGE_NUM_W + PAGE_BIT_W;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_IMM  = 2'd1,
    LD_SLOT = 2'd2,
    LD_NEW  = 2'd3
  } pseq_load_e;
endpackage

// File: rtl/pseq_slot.sv
module pseq_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         put,
  input  logic         take,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (clr || take) begin
      full <= 1'b0;
    end else if (put) begin
      full <= 1'b1;
      dout <= din;
    end
  end
endmodule

// File: rtl/pseq_addr_ctr.sv
module pseq_addr_ctr #(
  parameter int BIT_W  = 10,
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [BIT_W-1:0]  bit_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              at_last_bit,
  output logic              at_last_page
);
  localparam logic [BIT_W-1:0] BIT_MAX = {BIT_W{1'b1}};

  logic [CNT_W-1:0] left_q;

  assign at_last_bit  = (bit_q == BIT_MAX);
  assign at_last_page = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      page_q <= '0;
      left_q <= '0;
    end else if (load) begin
      bit_q  <= '0;
      page_q <= load_page;
      // count 0 wraps to all ones: sixteen pages
      left_q <= load_cnt - 1'b1;
    end else if (step) begin
      bit_q <= bit_q + 1'b1;
      if (at_last_bit) begin
        page_q <= page_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pseq_channel.sv
module pseq_channel
  import pseq_pkg::*;
#(
  parameter int BIT_W  = PAGE_BIT_W,
  parameter int PAGE_W = PAGE_NUM_W,
  parameter int CNT_W  = PAGE_CNT_W,
  localparam int CW    = CNT_W + PAGE_W,
  localparam int AW    = PAGE_W + BIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_imm,
  input  logic [CW-1:0] cmd_word,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done
);
  logic              active_q, req_q, done_q;
  logic              slot_full;
  logic [CW-1:0]     slot_word, ld_word;
  logic [BIT_W-1:0]  bit_q;
  logic [PAGE_W-1:0] page_q;
  logic              last_bit, last_page;
  logic              hs, last, acc;
  pseq_load_e        ld_sel;

  assign hs        = req_q & req_ready;
  assign last      = hs & last_bit & last_page;
  assign cmd_ready = cmd_imm | ~slot_full;
  assign acc       = cmd_valid & cmd_ready;

  always_comb begin
    ld_sel = LD_NONE;
    if (acc && cmd_imm)                          ld_sel = LD_IMM;
    else if (last && slot_full)                  ld_sel = LD_SLOT;
    else if (acc && (!active_q || last))         ld_sel = LD_NEW;
  end

  assign ld_word = (ld_sel == LD_SLOT) ? slot_word : cmd_word;

  pseq_slot #(.W(CW)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .put  (acc && !cmd_imm && active_q && !last),
    .take (ld_sel == LD_SLOT),
    .clr  (ld_sel == LD_IMM),
    .din  (cmd_word),
    .full (slot_full),
    .dout (slot_word)
  );

  pseq_addr_ctr #(.BIT_W(BIT_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ld_sel != LD_NONE),
    .load_page   (ld_word[PAGE_W-1:0]),
    .load_cnt    (ld_word[CW-1:PAGE_W]),
    .step        (hs && ld_sel == LD_NONE),
    .bit_q       (bit_q),
    .page_q      (page_q),
    .at_last_bit (last_bit),
    .at_last_page(last_page)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (ld_sel != LD_NONE) active_q <= 1'b1;
      else if (last)         active_q <= 1'b0;
      if (ld_sel == LD_IMM || hs)        req_q <= 1'b0;
      else if (tick && active_q && !req_q) req_q <= 1'b1;
    end
  end

  assign req_valid = req_q;
  assign req_addr  = {page_q, bit_q};
  assign busy      = active_q;
  assign done      = done_q;
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int BIT_W  = PAGE_BIT_W,
  parameter int PAGE_W = PAGE_NUM_W,
  parameter int CNT_W  = PAGE_CNT_W,
  localparam int CW    = CNT_W + PAGE_W,
  localparam int AW    = PAGE_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tick,
  input  logic [NCH-1:0]    cmd_valid,
  output logic [NCH-1:0]    cmd_ready,
  input  logic [NCH-1:0]    cmd_imm,
  input  logic [NCH*CW-1:0] cmd_word,
  output logic [NCH-1:0]    req_valid,
  input  logic [NCH-1:0]    req_ready,
  output logic [NCH-1:0]    req_write,
  output logic [NCH*AW-1:0] req_addr,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    done
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // channel 0 records (writes), the others play back (read)
    assign req_write[g] = (g == 0);

    pseq_channel #(.BIT_W(BIT_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick[g]),
      .cmd_valid(cmd_valid[g]),
      .cmd_ready(cmd_ready[g]),
      .cmd_imm  (cmd_imm[g]),
      .cmd_word (cmd_word[g*CW +: CW]),
      .req_valid(req_valid[g]),
      .req_ready(req_ready[g]),
      .req_addr (req_addr[g*AW +: AW]),
      .busy     (busy[g]),
      .done     (done[g])
    );
  end
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
  parameter int NCH   = 2,
  parameter int BIT_W = 10,
  parameter int AW    = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    cmd_valid,
  input logic [NCH-1:0]    cmd_ready,
  input logic [NCH-1:0]    cmd_imm,
  input logic [NCH-1:0]    req_valid,
  input logic [NCH-1:0]    req_ready,
  input logic [NCH*AW-1:0] req_addr,
  input logic [NCH-1:0]    busy,
  input logic [NCH-1:0]    done
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic [AW-1:0] a;
    assign a = req_addr[g*AW +: AW];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && !req_ready[g] && !(cmd_valid[g] && cmd_imm[g]))
      |=> (req_valid[g] && $stable(a))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done[g] |=> !done[g]); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done[g] |-> $past(req_valid[g] && req_ready[g] && (a[BIT_W-1:0] == {BIT_W{1'b1}}))); // R6

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[g] |-> !req_valid[g]); // R9

    AST_IMM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid[g] && cmd_imm[g]) |-> cmd_ready[g]); // R7
  end
endmodule

bind pseq_top pseq_chk #(.NCH(NCH), .BIT_W(BIT_W), .AW(AW)) u_pseq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_imm  (cmd_imm),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_pseq_top.sv
module tb_pseq_top;
  localparam int NCH = 2;
  localparam int BW  = 10;
  localparam int PW  = 12;
  localparam int AW  = 22;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [NCH-1:0]    tick;
  logic [NCH-1:0]    man_tick = '0;
  logic [NCH-1:0]    tick_en = '0;
  logic              ph = 1'b0;
  logic [NCH-1:0]    cmd_valid = '0, cmd_imm = '0, req_ready = '1;
  logic [NCH*16-1:0] cmd_word = '0;
  logic [NCH-1:0]    cmd_ready, req_valid, req_write, busy, done;
  logic [NCH*AW-1:0] req_addr;

  assign tick = man_tick | (tick_en & {NCH{ph}});

  pseq_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_imm(cmd_imm), .cmd_word(cmd_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .busy(busy), .done(done)
  );

  int errors = 0, checks = 0, cyc = 0;
  int bits[NCH], dones[NCH], aerr[NCH], last_hs[NCH], max_gap[NCH];
  logic [PW-1:0] ep[NCH], np[NCH];
  logic [BW-1:0] eb[NCH];
  logic          ea[NCH], nv[NCH];

  initial for (int c = 0; c < NCH; c++) begin
    bits[c] = 0; dones[c] = 0; aerr[c] = 0; last_hs[c] = -1; max_gap[c] = 0;
    ep[c] = '0; np[c] = '0; eb[c] = '0; ea[c] = 1'b0; nv[c] = 1'b0;
  end

  initial forever begin
    @(posedge clk); #1 ph = ~ph;
  end

  // reference model of the address sequence, built from the requirements
  always @(negedge clk) begin
    cyc++;
    if (rst_n) for (int c = 0; c < NCH; c++) begin
      if (done[c]) begin
        dones[c]++;
        if (nv[c]) begin ep[c] = np[c]; eb[c] = '0; nv[c] = 1'b0; end
        else ea[c] = 1'b0;
      end
      if (req_valid[c] && req_ready[c]) begin
        if (req_addr[c*AW +: AW] != {ep[c], eb[c]}) aerr[c]++;
        bits[c]++;
        if (last_hs[c] >= 0 && cyc - last_hs[c] > max_gap[c]) max_gap[c] = cyc - last_hs[c];
        last_hs[c] = cyc;
        eb[c] = eb[c] + 1'b1;
        if (eb[c] == '0) ep[c] = ep[c] + 1'b1;
      end
      if (cmd_valid[c] && cmd_ready[c]) begin
        if (cmd_imm[c] || !ea[c]) begin
          ep[c] = cmd_word[c*16 +: PW]; eb[c] = '0; ea[c] = 1'b1;
          if (cmd_imm[c]) nv[c] = 1'b0;
        end else begin
          np[c] = cmd_word[c*16 +: PW]; nv[c] = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear(input int c);
    @(posedge clk); #1;
    bits[c] = 0; dones[c] = 0; aerr[c] = 0; last_hs[c] = -1; max_gap[c] = 0;
  endtask

  task automatic send(input int c, input logic [15:0] w, input logic imm, output logic rdy);
    @(posedge clk); #1;
    cmd_valid[c] = 1'b1; cmd_imm[c] = imm; cmd_word[c*16 +: 16] = w;
    @(negedge clk); rdy = cmd_ready[c];
    @(posedge clk); #1;
    cmd_valid[c] = 1'b0;
  endtask

  task automatic wait_done(input int c, input int n);
    while (dones[c] < n) @(negedge clk);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {channel, command word}
  localparam logic [16:0] VEC [4] = '{17'h0_1005, 17'h1_2FFF, 17'h0_3010, 17'h1_0400};

  logic r;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", busy, 0);
    chk("R11 req_valid after reset", req_valid, 0);
    chk("R11 done after reset", done, 0);
    chk("R11 cmd_ready after reset", cmd_ready, 3);
    tick_en = '1;

    for (int i = 0; i < 4; i++) begin
      int c, pg;
      c  = int'(VEC[i][16]);
      pg = (VEC[i][15:12] == 4'd0) ? 16 : int'(VEC[i][15:12]);
      clear(c);
      send(c, VEC[i][15:0], 1'b1, r);
      wait_done(c, 1);
      idle_wait(20);
      chk($sformatf("R2 request count vec%0d", i), bits[c], pg * 1024);
      chk($sformatf("R1 R5 address sequence errors vec%0d", i), aerr[c], 0);
      chk($sformatf("R6 completion pulses vec%0d", i), dones[c], 1);
      chk($sformatf("R9 idle after vec%0d", i), {busy[c], req_valid[c]}, 0);
    end

    // back-pressure and dropped ticks
    tick_en = '0;
    clear(0);
    req_ready[0] = 1'b0;
    send(0, 16'h1200, 1'b1, r);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 man_tick[0] = 1'b1;
      @(posedge clk); #1 man_tick[0] = 1'b0;
    end
    @(negedge clk);
    chk("R4 request held", req_valid[0], 1);
    chk("R4 address held", req_addr[AW-1:0], 22'h080000);
    @(posedge clk); #1 req_ready[0] = 1'b1;
    idle_wait(6);
    chk("R3 one request for several ticks", bits[0], 1);
    chk("R3 request cleared", req_valid[0], 0);
    tick_en = '1;
    wait_done(0, 1);
    chk("R3 remaining page completes", bits[0], 1024);
    chk("R1 back-pressure address errors", aerr[0], 0);

    // immediate replacement discards a waiting command
    clear(0);
    send(0, 16'h2020, 1'b1, r);
    while (bits[0] < 100) @(negedge clk);
    send(0, 16'h1300, 1'b0, r);
    chk("R8 buffered accepted while busy", r, 1);
    send(0, 16'h1100, 1'b1, r);
    chk("R7 immediate accepted", r, 1);
    wait_done(0, 1);
    idle_wait(40);
    chk("R7 single completion", dones[0], 1);
    chk("R7 idle after replacement", busy[0], 0);
    chk("R7 address errors", aerr[0], 0);

    // buffered hand-over and full slot
    clear(1);
    send(1, 16'h1050, 1'b1, r);
    send(1, 16'h1060, 1'b0, r);
    chk("R8 first buffered accepted", r, 1);
    send(1, 16'h1070, 1'b0, r);
    chk("R8 second buffered refused", r, 0);
    wait_done(1, 2);
    idle_wait(20);
    chk("R8 two commands, bit count", bits[1], 2048);
    chk("R8 no gap at hand-over", max_gap[1], 2);
    chk("R8 hand-over address errors", aerr[1], 0);
    chk("R8 two completions", dones[1], 2);

    // buffered on idle channel starts at once
    clear(0);
    send(0, 16'h1123, 1'b0, r);
    idle_wait(4);
    chk("R8 buffered on idle starts", busy[0], 1);
    wait_done(0, 1);
    chk("R8 buffered on idle bit count", bits[0], 1024);

    // both channels together
    clear(0); clear(1);
    send(0, 16'h1040, 1'b1, r);
    send(1, 16'h1080, 1'b1, r);
    wait_done(0, 1);
    wait_done(1, 1);
    idle_wait(20);
    chk("R10 record count", bits[0], 1024);
    chk("R10 play count", bits[1], 1024);
    chk("R10 address errors", aerr[0] + aerr[1], 0);
    chk("R10 write flags", req_write, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 160000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule